// File: doc/BRIEF.md
# Dynamic Bus Sizing Lane Steerer

This block connects a 32-bit big-endian operand path to an external 32-bit data bus. The device on the far side may be 32, 16 or 8 bits wide, and a memory controller reports that width for each access. The block takes one byte, half-word or word request at a time. It places each operand byte on the lanes that the port width allows. When the port is narrower than the operand, it splits the access into back-to-back bus cycles. For reads, it collects the bytes returned on the narrow lanes into their proper operand positions.

Lanes use big-endian numbering. Lane 0 is bits 31:24 of the bus vectors and lane 3 is bits 7:0. A narrow port always sits on the lowest-numbered lanes. Operand byte n of `wdata` and `rdata` sits in the same bit range as lane n. A word access is first planned as a full-width transfer and is then cut into as many cycles as the port width needs. A request whose address does not suit its size gets an error completion and produces no bus cycle.

Top module: `bus_sizer`

## Requirements
- R1: A request taken while idle starts its first bus cycle (`bus_valid`=1) on the next clock. `busy` is high while bus cycles are pending. `done` is high for exactly one clock, the one after the `ta` of the last bus cycle. A completion with no fault has `err`=0.
- R2: A word with `addr[1:0]`≠0, or a half-word with `addr[0]`=1, is a misalignment. On the next clock `done`=1 and `err`=1, and no bus cycle is started.
- R3: On a 32-bit port (`port_sz`=0), every access takes one bus cycle. `bus_addr` is the request address, and the enabled lanes are the operand's own byte positions. `bus_be` bit 3 enables lane 0 and bit 0 enables lane 3.
- R4: On a 16-bit port (`port_sz`=1), only lanes 0–1 are used. A word takes two cycles, at byte offsets 0 and 2. A half-word takes one cycle on lanes 0–1. A byte uses lane `addr[0]`.
- R5: On an 8-bit port (`port_sz`=2), only lane 0 is used. The cycle count equals the operand byte count, and the addresses rise by one per cycle from the request address.
- R6: The port width is honoured only when `ctl_int`=1. Otherwise the access runs as on a 32-bit port (`port_sz`=3 also means 32 bits).
- R7: For writes, each enabled lane carries the operand byte being transferred in that cycle. Every other lane carries `wdata` at its natural 32-bit position.
- R8: For reads, `rdata` is cleared when the request is taken. Each operand byte is loaded only from the enabled lane of its own cycle. At `done`, `rdata` holds the assembled operand, with zero in the byte positions that are not part of the operand.
- R9: While `bus_valid`=1 and `ta`=0, the cycle's address, size and byte enables stay unchanged.
- R10: `bus_size` gives the byte count of the current cycle as 0=1, 1=2 or 2=4 bytes, and it matches the number of set `bus_be` bits. The request `size` uses the same encoding: 0 byte, 1 half-word, 2 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken when idle |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Operand size: 0 byte, 1 half-word, 2 word |
| addr | input | ADDR_W | Byte address of the operand |
| wdata | input | 32 | Write operand in natural lane positions |
| port_sz | input | 2 | Port width: 0 = 32, 1 = 16, 2 = 8 bits |
| ctl_int | input | 1 | Access under internal memory controller; enables narrow ports |
| busy | output | 1 | Bus cycles in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Misalignment flag, valid with done |
| rdata | output | 32 | Assembled read operand |
| bus_valid | output | 1 | A bus cycle is presented |
| bus_wr | output | 1 | Direction of the bus cycle |
| bus_addr | output | ADDR_W | Byte address of the bus cycle |
| bus_size | output | 2 | Bytes in this cycle, log2 |
| bus_be | output | 4 | Lane enables, bit 3 = lane 0 |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Data returned by the slave |
| ta | input | 1 | Transfer acknowledge for the current cycle |

## Verification
Assertions check these on every clock: the single-cycle `done` pulse, the abort of a misaligned request with no bus cycle, the holding of a cycle while it waits for acknowledge, the restriction of enables to the port's lanes, and the agreement between `bus_size` and the enable count. The bench scenarios are needed for the rest. They show the exact byte-to-lane mapping, the addresses of the split cycles, the natural data kept on unused write lanes, the assembly of read bytes returned by a port-width slave model that fills unused lanes with junk, and the fallback to full width when the memory controller is not in charge.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_FIN} bsz_state_e;

  localparam int          BUS_BYTES = 4;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] PS_16   = 2'd1;
  localparam logic [1:0] PS_8    = 2'd2;

  // log2 of the effective port width in bytes
  function automatic logic [1:0] port_log(input logic [1:0] ps, input logic honour);
    if (!honour) return 2'd2;
    case (ps)
      PS_16:   return 2'd1;
      PS_8:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/bsz_seq.sv
module bsz_seq
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        port_sz,
  input  logic              ctl_int,
  input  logic              ta,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_valid,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        offs,
  output logic [1:0]        bw_l,
  output logic [1:0]        plog,
  output logic [31:0]       op_wd,
  output logic              start,
  output logic              cap
);
  bsz_state_e        st;
  logic [ADDR_W-1:0] a_addr;
  logic [1:0]        a_sz, a_plog, beat, last, szl;
  logic              a_wr, a_err, mis, take;
  logic [31:0]       a_wd;
  logic [2:0]        nbeat;

  assign szl  = (size == 2'd3) ? SZ_WORD : size;
  assign mis  = (szl == SZ_WORD && addr[1:0] != 2'b00) || (szl == SZ_HALF && addr[0]);
  assign take = req && (st == ST_IDLE);

  // width of one bus cycle: smaller of operand and port
  assign bw_l  = (a_sz < a_plog) ? a_sz : a_plog;
  assign nbeat = 3'd1 << (a_sz - bw_l);
  assign last  = nbeat[1:0] - 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      beat   <= '0;
      a_err  <= 1'b0;
      a_addr <= '0;
      a_sz   <= '0;
      a_plog <= 2'd2;
      a_wr   <= 1'b0;
      a_wd   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req) begin
          a_err <= mis;
          beat  <= '0;
          if (mis) st <= ST_FIN;
          else begin
            st     <= ST_BUS;
            a_addr <= addr;
            a_sz   <= szl;
            a_plog <= port_log(port_sz, ctl_int);
            a_wr   <= wr;
            a_wd   <= wdata;
          end
        end
        ST_BUS: if (ta) begin
          if (beat == last) st <= ST_FIN;
          else beat <= beat + 2'd1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign offs      = a_addr[1:0] + (beat << bw_l);
  assign bus_addr  = {a_addr[ADDR_W-1:2], offs};
  assign bus_valid = (st == ST_BUS);
  assign busy      = bus_valid;
  assign bus_wr    = a_wr;
  assign plog      = a_plog;
  assign op_wd     = a_wd;
  assign done      = (st == ST_FIN);
  assign err       = done && a_err;
  assign start     = take && !mis;
  assign cap       = bus_valid && ta && !a_wr;

  assert_single_done_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_misalign_abort_R2: assert property (@(posedge clk) disable iff (rst)
    (take && mis) |=> (done && err && !bus_valid));
  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !ta) |=> (bus_valid && $stable(bus_addr) && $stable(bw_l)));
endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes
  import bsz_pkg::*;
(
  input  logic [1:0]  offs,
  input  logic [1:0]  bw_l,
  input  logic [1:0]  plog,
  input  logic [31:0] wd,
  output logic [1:0]  lstart,
  output logic [3:0]  be,
  output logic [31:0] wd_out
);
  logic [2:0] bw, pmask, ls;
  logic [7:0] opb [BUS_BYTES];

  assign bw     = 3'd1 << bw_l;
  assign pmask  = (3'd1 << plog) - 3'd1;
  assign ls     = {1'b0, offs} & pmask;
  assign lstart = ls[1:0];

  for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
    logic       hit;
    logic [2:0] src;
    assign opb[l] = wd[31-8*l -: 8];
    assign hit    = (3'(l) >= ls) && (3'(l) < ls + bw);
    assign src    = {1'b0, offs} + 3'(l) - ls;
    assign be[BUS_BYTES-1-l]  = hit;
    assign wd_out[31-8*l -: 8] = hit ? opb[src[1:0]] : opb[l];
  end
endmodule

// File: rtl/bsz_gather.sv
module bsz_gather
  import bsz_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        cap,
  input  logic [1:0]  offs,
  input  logic [1:0]  bw_l,
  input  logic [1:0]  lstart,
  input  logic [31:0] lanes_in,
  output logic [31:0] rdata
);
  logic [2:0] bw;
  logic [7:0] lb [BUS_BYTES];
  logic [7:0] rb [BUS_BYTES];

  assign bw = 3'd1 << bw_l;

  for (genvar n = 0; n < BUS_BYTES; n++) begin : g_byte
    logic       hit;
    logic [2:0] lane;
    assign lb[n] = lanes_in[31-8*n -: 8];
    assign hit   = (3'(n) >= {1'b0, offs}) && (3'(n) < {1'b0, offs} + bw);
    assign lane  = {1'b0, lstart} + 3'(n) - {1'b0, offs};
    always_ff @(posedge clk) begin
      if (rst || clr)     rb[n] <= '0;
      else if (cap && hit) rb[n] <= lb[lane[1:0]];
    end
    assign rdata[31-8*n -: 8] = rb[n];
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        port_sz,
  input  logic              ctl_int,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic              bus_valid,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [3:0]        bus_be,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              ta
);
  logic [1:0]  offs, bw_l, plog, lstart;
  logic [31:0] op_wd;
  logic        start, cap;

  bsz_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst, .req, .wr, .size, .addr, .wdata, .port_sz, .ctl_int, .ta,
    .busy, .done, .err, .bus_valid, .bus_wr, .bus_addr,
    .offs, .bw_l, .plog, .op_wd, .start, .cap
  );

  bsz_lanes u_lanes (
    .offs, .bw_l, .plog, .wd(op_wd), .lstart, .be(bus_be), .wd_out(bus_wdata)
  );

  bsz_gather u_gather (
    .clk, .rst, .clr(start), .cap, .offs, .bw_l, .lstart,
    .lanes_in(bus_rdata), .rdata
  );

  assign bus_size = bw_l;

  assert_lanes16_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && plog == 2'd1) |-> (bus_be[1:0] == 2'b00));
  assert_lanes8_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && plog == 2'd0) |-> (bus_be[2:0] == 3'b000));
  assert_be_count_R10: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ($countones(bus_be) == (1 << bus_size)));
endmodule

// File: tb/bus_sizer_bench.sv
module bus_sizer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req = 0, wr = 0, ctl_int = 0, ta = 0;
  logic [1:0]  size = 0, port_sz = 0;
  logic [31:0] addr = 0, wdata = 0, bus_rdata = 0;
  logic        busy, done, err, bus_valid, bus_wr;
  logic [31:0] rdata, bus_addr, bus_wdata;
  logic [1:0]  bus_size;
  logic [3:0]  bus_be;

  bus_sizer u_bus_sizer (
    .clk, .rst, .req, .wr, .size, .addr, .wdata, .port_sz, .ctl_int,
    .busy, .done, .err, .rdata, .bus_valid, .bus_wr, .bus_addr,
    .bus_size, .bus_be, .bus_wdata, .bus_rdata, .ta
  );

  int checks = 0, fails = 0, cyc = 0, seq = 0;
  logic [7:0] mem [4];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic access(input bit w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [1:0] ps, input bit ci, input logic [31:0] wd,
                        input int waits);
    int pb, nb, bw, nbe, k, wc, guard, o, ls, base;
    bit mis, tak;
    string tag;
    logic [31:0] e_addr, e_wd, e_rd, sl;
    logic [3:0]  e_be;
    logic [1:0]  e_sz;
    seq++;
    for (int n = 0; n < 4; n++) mem[n] = 8'(8'h31 * (n + 1) + seq);
    pb  = (!ci || ps == 2'd0 || ps == 2'd3) ? 4 : (ps == 2'd1 ? 2 : 1);
    nb  = 1 << sz;
    bw  = (nb < pb) ? nb : pb;
    nbe = nb / bw;
    tag = (ps != 0 && !ci) ? "R6" : (pb == 4 ? "R3" : (pb == 2 ? "R4" : "R5"));
    mis = (sz == 2'd2 && a[1:0] != 0) || (sz == 2'd1 && a[0]);
    req = 1; wr = w; size = sz; addr = a; wdata = wd; port_sz = ps; ctl_int = ci;
    @(negedge clk);
    req = 0;
    if (mis) begin
      chk(done && err && !bus_valid && !busy, "R2", "abort", {done, err, bus_valid, busy}, 4'b1100);
      @(negedge clk);
      chk(!done && !bus_valid, "R2", "no bus cycle", {done, bus_valid}, 2'b00);
      return;
    end
    k = 0; wc = 0; guard = 0;
    while (!done && guard < 100) begin
      guard++;
      tak = 0;
      if (bus_valid && k < nbe) begin
        o = a[1:0] + k * bw;
        ls = o % pb;
        e_addr = {a[31:2], 2'b00} + o;
        e_be = '0; e_wd = wd;
        for (int i = 0; i < bw; i++) begin
          e_be[3-(ls+i)] = 1'b1;
          e_wd[31-8*(ls+i) -: 8] = wd[31-8*(o+i) -: 8];
        end
        e_sz = (bw == 4) ? 2'd2 : (bw == 2 ? 2'd1 : 2'd0);
        chk(bus_addr == e_addr, wc > 0 ? "R9" : tag, "bus_addr", bus_addr, e_addr);
        chk(bus_be == e_be, wc > 0 ? "R9" : tag, "bus_be", 32'(bus_be), 32'(e_be));
        chk(bus_size == e_sz, "R10", "bus_size", 32'(bus_size), 32'(e_sz));
        chk(busy && bus_wr == w, "R1", "busy/dir", {busy, bus_wr}, {1'b1, w});
        if (w) chk(bus_wdata == e_wd, "R7", "bus_wdata", bus_wdata, e_wd);
        tak = (wc >= waits);
        if (tak) begin
          base = bus_addr[1:0] - (bus_addr[1:0] % pb);
          sl = 32'hEEEE_EEEE;
          for (int j = 0; j < pb; j++) sl[31-8*j -: 8] = mem[base+j];
          bus_rdata = sl;
        end
      end else begin
        chk(0, "R1", "bus cycle missing", {bus_valid, 8'(k)}, {1'b1, 8'(nbe)});
      end
      ta = tak;
      @(negedge clk);
      ta = 0;
      if (tak) begin k++; wc = 0; end else wc++;
    end
    chk(done && !err && !busy, "R1", "completion", {done, err, busy}, 3'b100);
    chk(k == nbe, tag, "cycle count", k, nbe);
    if (!w) begin
      e_rd = '0;
      for (int n = a[1:0]; n < a[1:0] + nb; n++) e_rd[31-8*n -: 8] = mem[n];
      chk(rdata == e_rd, "R8", "rdata", rdata, e_rd);
    end
    @(negedge clk);
    chk(!done, "R1", "done pulse length", done, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk(!busy && !done && !bus_valid, "R1", "reset state", {busy, done, bus_valid}, 0);
    rst = 0;
    @(negedge clk);
    // full-width port
    access(0, 2'd2, 32'h1000_0000, 2'd0, 1, 0, 0);
    access(1, 2'd2, 32'h1000_0004, 2'd0, 1, 32'hA1B2C3D4, 1);
    access(1, 2'd1, 32'h1000_0002, 2'd0, 1, 32'h1122_3344, 0);
    access(0, 2'd0, 32'h1000_0001, 2'd0, 1, 0, 0);
    access(1, 2'd0, 32'h1000_0003, 2'd0, 1, 32'h5566_7788, 2);
    // 16-bit port
    access(0, 2'd2, 32'h2000_0010, 2'd1, 1, 0, 2);
    access(1, 2'd2, 32'h2000_0014, 2'd1, 1, 32'hDEAD_BEEF, 0);
    access(0, 2'd1, 32'h2000_0002, 2'd1, 1, 0, 1);
    access(0, 2'd0, 32'h2000_0003, 2'd1, 1, 0, 0);
    access(1, 2'd1, 32'h2000_0002, 2'd1, 1, 32'hCAFE_F00D, 0);
    // 8-bit port
    access(1, 2'd2, 32'h3000_0020, 2'd2, 1, 32'h0102_0304, 1);
    access(0, 2'd2, 32'h3000_0024, 2'd2, 1, 0, 0);
    access(0, 2'd1, 32'h3000_0002, 2'd2, 1, 0, 3);
    access(1, 2'd1, 32'h3000_0000, 2'd2, 1, 32'h9988_7766, 0);
    access(0, 2'd0, 32'h3000_0002, 2'd2, 1, 0, 0);
    // narrow width ignored without internal controller
    access(0, 2'd2, 32'h4000_0000, 2'd2, 0, 0, 0);
    access(1, 2'd2, 32'h4000_0008, 2'd1, 0, 32'h1357_9BDF, 1);
    // misaligned
    access(0, 2'd2, 32'h5000_0002, 2'd1, 1, 0, 0);
    access(1, 2'd2, 32'h5000_0001, 2'd0, 1, 32'hFFFF_FFFF, 0);
    access(0, 2'd1, 32'h5000_0003, 2'd2, 1, 0, 0);
    // aligned access straight after an abort
    access(0, 2'd1, 32'h5000_0000, 2'd2, 1, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule